// File: doc/BRIEF.md
# Multi-Master Priority Bus Arbiter

This block decides which of several masters owns the address bus of a processor-local bus. Each master drives a request line, a 2-bit priority that comes with the request rather than being tied to its port, and a lock qualifier. The arbiter installs one owner at a time and marks each installation with a one-cycle grant pulse. The owner's address tenure lasts until the addressed slave returns an address acknowledge.

While a tenure runs, the arbiter keeps choosing the next owner and holds that choice in a register. When the acknowledge arrives, the registered choice takes over on the very next edge, with no idle cycle in between. A master that asserts lock keeps the bus across acknowledges, so an atomic sequence is not broken up. The lock stops counting after a bounded number of cycles, so no locked master can hold the bus forever.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `grant` is all zero and `owner_valid` is low. After reset the round-robin search starts at master 0.
- R2: With no owner and no request, no grant is issued and `owner_valid` stays low.
- R3: Priority is an unsigned 2-bit value per master, held in `req_prio[2*i+1:2*i]`, and 3 is the most urgent. Among the requests taking part, the highest value wins.
- R4: Among requests at the winning priority, the search starts at the master after the one granted last and wraps from master N-1 to master 0.
- R5: `grant` has at most one bit set. The bit is set only in the cycle right after an ownership decision, and the set bit matches `owner_id`.
- R6: When there is no owner and at least one request, the winner is granted at the next edge. It becomes the owner, and `grant` pulses in the following cycle.
- R7: While there is an owner and `addr_ack` is low, `owner_valid` and `owner_id` do not change.
- R8: Every cycle a candidate is registered from the requests, using the owner and round-robin state being installed at that edge. In a cycle with `addr_ack` high and no lock hold, the candidate takes over at the next edge if it still requests. Otherwise the bus goes idle.
- R9: If the owner has `req_lock` and `req` high in a cycle with `addr_ack` high, and its lock count is below LOCK_LIMIT, it keeps the bus and gets a new grant pulse.
- R10: The lock count starts at 0 when an owner is installed or released. It rises by one per cycle while the owner holds lock, up to LOCK_LIMIT (64), and clears when lock drops. Once the count reaches LOCK_LIMIT, the next acknowledge hands the bus on.
- R11: The current owner, or the owner being installed, is never its own candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Per-master bus request |
| req_prio | input | N_MASTERS*PRIO_W | Per-master request priority, 3 most urgent |
| req_lock | input | N_MASTERS | Per-master lock qualifier for atomic sequences |
| addr_ack | input | 1 | Slave acknowledge ending the current address phase |
| grant | output | N_MASTERS | One-cycle one-hot grant pulse |
| owner_valid | output | 1 | An address tenure is in progress |
| owner_id | output | clog2(N_MASTERS) | Index of the current owner |

## Verification
The hardest state to reach from the ports is lock expiry under competition. A master must hold lock and request for more than 64 cycles with acknowledges arriving, while rivals with higher priority wait. Only then does the handover decision stop renewing and pass the bus on. A directed phase builds exactly this: one locked master at the lowest priority, three rivals at the highest, and the acknowledge tied high. The owner is checked before and after the 64-cycle bound. A phase with the acknowledge held high, including in grant cycles, covers back-to-back handovers. A long random phase with masters that drop their request after being granted covers candidates that go stale.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Ownership decision taken at each clock edge
  typedef enum logic [2:0] {
    HO_NONE,     // idle, nobody requesting
    HO_START,    // idle, install winner of direct pick
    HO_HOLD,     // owner active, no acknowledge yet
    HO_RENEW,    // acknowledge, owner kept by lock
    HO_PASS,     // acknowledge, registered candidate takes over
    HO_RELEASE   // acknowledge, nothing to hand over
  } handover_e;

endpackage

// File: rtl/bus_arb_pick.sv
module bus_arb_pick #(
  parameter int N   = 4,
  parameter int PW  = 2,
  parameter int IDW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  input  logic [IDW-1:0]  last,
  output logic            valid,
  output logic [IDW-1:0]  id
);

  always_comb begin : pick
    logic [PW-1:0]  top;
    logic           found;
    logic [IDW-1:0] idx;
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (prio[i*PW +: PW] > top)) top = prio[i*PW +: PW];
    end
    found = 1'b0;
    id    = '0;
    for (int k = 1; k <= N; k++) begin
      idx = IDW'((int'(last) + k) % N);
      if (!found && req[idx] && (prio[idx*PW +: PW] == top)) begin
        found = 1'b1;
        id    = idx;
      end
    end
    valid = |req;
  end

endmodule

// File: rtl/bus_arb_lock_timer.sv
module bus_arb_lock_timer #(
  parameter int LIMIT = 64,
  parameter int CW    = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic count_en,
  output logic expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)            cnt_q <= '0;
    else if (!count_en)            cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == CW'(LIMIT));

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LIMIT));

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expired);

endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter
  import bus_arb_pkg::*;
#(
  parameter int N_MASTERS  = 4,
  parameter int PRIO_W     = 2,
  parameter int LOCK_LIMIT = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_MASTERS-1:0]        req,
  input  logic [N_MASTERS*PRIO_W-1:0] req_prio,
  input  logic [N_MASTERS-1:0]        req_lock,
  input  logic                        addr_ack,
  output logic [N_MASTERS-1:0]        grant,
  output logic                        owner_valid,
  output logic [((N_MASTERS > 1) ? $clog2(N_MASTERS) : 1)-1:0] owner_id
);

  localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam int CW  = $clog2(LOCK_LIMIT + 1);

  logic                 owner_valid_q;
  logic [IDW-1:0]       owner_id_q;
  logic [IDW-1:0]       last_q;
  logic                 cand_valid_q;
  logic [IDW-1:0]       cand_id_q;
  logic [N_MASTERS-1:0] grant_q;

  logic                 idle_valid;
  logic [IDW-1:0]       idle_id;
  logic                 nxt_cand_valid;
  logic [IDW-1:0]       nxt_cand_id;
  logic [N_MASTERS-1:0] cand_req;

  handover_e            decision;
  logic                 nxt_valid;
  logic [IDW-1:0]       nxt_id;
  logic [IDW-1:0]       nxt_last;
  logic                 fire;
  logic                 restart;
  logic                 lock_expired;
  logic                 owner_locked;

  // Direct pick used only when the bus is idle
  bus_arb_pick #(.N(N_MASTERS), .PW(PRIO_W), .IDW(IDW)) u_pick_idle (
    .req   (req),
    .prio  (req_prio),
    .last  (last_q),
    .valid (idle_valid),
    .id    (idle_id)
  );

  assign owner_locked = owner_valid_q && req_lock[owner_id_q];

  bus_arb_lock_timer #(.LIMIT(LOCK_LIMIT), .CW(CW)) u_lock_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .count_en (owner_locked),
    .expired  (lock_expired)
  );

  // Handover decision for this edge
  always_comb begin
    if (!owner_valid_q)                                decision = idle_valid ? HO_START : HO_NONE;
    else if (!addr_ack)                                decision = HO_HOLD;
    else if (owner_locked && req[owner_id_q] && !lock_expired) decision = HO_RENEW;
    else if (cand_valid_q && req[cand_id_q])           decision = HO_PASS;
    else                                               decision = HO_RELEASE;
  end

  always_comb begin
    nxt_valid = owner_valid_q;
    nxt_id    = owner_id_q;
    nxt_last  = last_q;
    fire      = 1'b0;
    restart   = 1'b0;
    case (decision)
      HO_START: begin
        nxt_valid = 1'b1;
        nxt_id    = idle_id;
        nxt_last  = idle_id;
        fire      = 1'b1;
        restart   = 1'b1;
      end
      HO_RENEW: fire = 1'b1;
      HO_PASS: begin
        nxt_id   = cand_id_q;
        nxt_last = cand_id_q;
        fire     = 1'b1;
        restart  = 1'b1;
      end
      HO_RELEASE: begin
        nxt_valid = 1'b0;
        restart   = 1'b1;
      end
      default: ;
    endcase
  end

  // Overlapped pick for the next tenure, based on the state being installed
  always_comb begin
    cand_req = req;
    if (nxt_valid) cand_req[nxt_id] = 1'b0;
  end

  bus_arb_pick #(.N(N_MASTERS), .PW(PRIO_W), .IDW(IDW)) u_pick_next (
    .req   (cand_req),
    .prio  (req_prio),
    .last  (nxt_last),
    .valid (nxt_cand_valid),
    .id    (nxt_cand_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_valid_q <= 1'b0;
      owner_id_q    <= '0;
      last_q        <= IDW'(N_MASTERS - 1);
      cand_valid_q  <= 1'b0;
      cand_id_q     <= '0;
      grant_q       <= '0;
    end else begin
      owner_valid_q <= nxt_valid;
      owner_id_q    <= nxt_id;
      last_q        <= nxt_last;
      cand_valid_q  <= nxt_cand_valid;
      cand_id_q     <= nxt_cand_id;
      grant_q       <= fire ? (N_MASTERS'(1) << nxt_id) : '0;
    end
  end

  assign grant       = grant_q;
  assign owner_valid = owner_valid_q;
  assign owner_id    = owner_id_q;

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));

  assert_grant_matches_owner_R5: assert property (@(posedge clk) disable iff (rst)
    (|grant_q) |-> (owner_valid_q && grant_q[owner_id_q]));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!owner_valid_q && (req == '0)) |=> (!owner_valid_q && (grant_q == '0)));

  assert_idle_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (!owner_valid_q && (|req)) |=> (owner_valid_q && (|grant_q)));

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (owner_valid_q && !addr_ack) |=> (owner_valid_q && $stable(owner_id_q) && (grant_q == '0)));

  assert_lock_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (owner_valid_q && addr_ack && req_lock[owner_id_q] && req[owner_id_q] && !lock_expired)
      |=> (owner_valid_q && (owner_id_q == $past(owner_id_q)) && (|grant_q)));

  assert_cand_not_owner_R11: assert property (@(posedge clk) disable iff (rst)
    (owner_valid_q && cand_valid_q) |-> (cand_id_q != owner_id_q));

endmodule

// File: tb/bus_owner_arbiter_bench.sv
module bus_owner_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NM         = 4;
  localparam int LIM        = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic [NM-1:0] req;
  logic [2*NM-1:0] req_prio;
  logic [NM-1:0] req_lock;
  logic          addr_ack;
  logic [NM-1:0] grant;
  logic          owner_valid;
  logic [1:0]    owner_id;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit cmp_on = 1'b0;

  // reference state
  bit m_ov;
  int m_oid;
  int m_last;
  bit m_cv;
  int m_cid;
  int m_cnt;
  int m_g;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_owner_arbiter u_bus_owner_arbiter (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_prio    (req_prio),
    .req_lock    (req_lock),
    .addr_ack    (addr_ack),
    .grant       (grant),
    .owner_valid (owner_valid),
    .owner_id    (owner_id)
  );

  function automatic int ref_pick(logic [NM-1:0] r, logic [2*NM-1:0] p, int last);
    for (int lvl = 3; lvl >= 0; lvl--) begin
      for (int k = 1; k <= NM; k++) begin
        int i;
        i = (last + k) % NM;
        if (r[i] && (int'(p[2*i +: 2]) == lvl)) return i;
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ov = 0; m_oid = 0; m_last = NM - 1; m_cv = 0; m_cid = 0; m_cnt = 0; m_g = 0;
    end else begin
      bit nov, fire, rs;
      int noid, nlast, p;
      logic [NM-1:0] mr;
      nov = m_ov; noid = m_oid; nlast = m_last; fire = 0; rs = 0;
      if (!m_ov) begin
        p = ref_pick(req, req_prio, m_last);
        if (p >= 0) begin nov = 1; noid = p; nlast = p; fire = 1; rs = 1; end
      end else if (addr_ack) begin
        if (req_lock[m_oid] && req[m_oid] && m_cnt < LIM) fire = 1;
        else if (m_cv && req[m_cid]) begin noid = m_cid; nlast = m_cid; fire = 1; rs = 1; end
        else begin nov = 0; rs = 1; end
      end
      if (rs) m_cnt = 0;
      else if (m_ov && req_lock[m_oid]) begin if (m_cnt < LIM) m_cnt++; end
      else m_cnt = 0;
      mr = req;
      if (nov) mr[noid] = 1'b0;
      p = ref_pick(mr, req_prio, nlast);
      m_cv = (p >= 0);
      m_cid = (p >= 0) ? p : 0;
      m_g = fire ? (1 << noid) : 0;
      m_ov = nov; m_oid = noid; m_last = nlast;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison, outputs are registered so negedge is stable
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R5 R8 grant vs model", int'(grant), m_g);
      check("R7 owner_valid vs model", int'(owner_valid), int'(m_ov));
      if (m_ov) check("R11 R4 owner_id vs model", int'(owner_id), m_oid);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1; req = '0; req_lock = '0; addr_ack = 1'b0; req_prio = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; req = '0; req_prio = '0; req_lock = '0; addr_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 grant in reset", int'(grant), 0);
    check("R1 owner_valid in reset", int'(owner_valid), 0);
    cmp_on = 1'b1;
    rst = 1'b0;

    // R2 idle without requests
    repeat (5) @(negedge clk);
    check("R2 idle grant", int'(grant), 0);
    check("R2 idle owner_valid", int'(owner_valid), 0);

    // R3 priority: m0 at 1, m2 at 3
    req = 4'b0101; req_prio = {2'd0, 2'd3, 2'd0, 2'd1};
    @(negedge clk);
    check("R3 higher priority wins", int'(grant), 4'b0100);
    check("R6 owner after idle request", int'(owner_valid), 1);
    req = '0; addr_ack = 1'b1;
    @(negedge clk);
    addr_ack = 1'b0;
    @(negedge clk);
    check("R8 release without candidate", int'(owner_valid), 0);

    // R4 round robin from reset, equal priorities
    do_reset();
    req = 4'b1111; req_prio = {2'd2, 2'd2, 2'd2, 2'd2};
    @(negedge clk);
    check("R4 first equal-priority grant", int'(grant), 4'b0001);
    req = 4'b1110; addr_ack = 1'b1;
    @(negedge clk);
    addr_ack = 1'b0;
    check("R4 R8 next grant without gap", int'(grant), 4'b0010);
    req = 4'b1100;
    // R7 hold without acknowledge
    repeat (10) @(negedge clk);
    check("R7 owner held", int'(owner_id), 1);
    check("R7 no grant while held", int'(grant), 0);
    req = '0; addr_ack = 1'b1;
    repeat (3) @(negedge clk);
    addr_ack = 1'b0;

    // R9 R10 lock hold and expiry
    do_reset();
    req = 4'b0010; req_lock = 4'b0010; req_prio = {2'd3, 2'd3, 2'd0, 2'd3};
    @(negedge clk);
    check("R9 locked master granted", int'(owner_id), 1);
    req = 4'b1111; addr_ack = 1'b1;
    repeat (60) @(negedge clk);
    check("R9 lock keeps ownership", int'(owner_id), 1);
    repeat (15) @(negedge clk);
    check("R10 lock expiry hands over", int'(owner_id != 2'd1), 1);
    req = '0; req_lock = '0;
    repeat (3) @(negedge clk);
    addr_ack = 1'b0;

    // back-to-back handovers, acknowledge always high
    do_reset();
    req = 4'b1111; req_prio = {2'd1, 2'd3, 2'd3, 2'd0}; addr_ack = 1'b1;
    repeat (200) @(negedge clk);

    // random behavioural masters and slave
    do_reset();
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      for (int i = 0; i < NM; i++) begin
        if (grant[i]) begin
          if ($urandom % 4 != 0) req[i] = 1'b0;
        end else if (!req[i] && ($urandom % 4 == 0)) begin
          req[i] = 1'b1;
          req_prio[2*i +: 2] = 2'($urandom % 4);
          req_lock[i] = ($urandom % 5 == 0);
        end
      end
      addr_ack = ($urandom % 3 == 0);
    end

    @(negedge clk);
    cmp_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule